// File: doc/BRIEF.md
# Sixteen-Bit ALU with Overflow Word

This block is a purely combinational arithmetic and logic unit for a small 16-bit processor. An opcode and two operands, `a` and `b`, go in. Out come the value to write back into the destination and a full 16-bit overflow word. A write-enable tells the register file whether that overflow word should replace the stored one.

The arithmetic opcodes do not report a single carry bit. Each one places its own content into the overflow word:

- Addition reports a carry.
- Subtraction reports a borrow mask.
- Multiplication reports the high product half.
- Division reports the fraction.
- The shifts report the bits shifted out.

Copy, modulo and the bitwise operations leave the overflow register alone.

Operand fetch, register storage and conditional skips belong to the surrounding core. The unit has no clock, and its outputs follow its inputs within the same cycle.

Top module: `ovw_alu`

## Requirements
- R1: Opcode 0x1 (copy) gives `res` = `b` and `ovf_we` = 0.
- R2: Opcode 0x2 (add) gives `res` = (`a`+`b`) mod 2^16. `ovf` is 0x0001 when the true sum exceeds 0xffff and 0x0000 otherwise. `ovf_we` = 1.
- R3: Opcode 0x3 (subtract) gives `res` = (`a`-`b`) mod 2^16. `ovf` is 0xffff when `b` > `a` and 0x0000 otherwise. `ovf_we` = 1.
- R4: Opcode 0x4 (multiply) gives the low 16 bits of the 32-bit product in `res` and the high 16 bits in `ovf`. `ovf_we` = 1.
- R5: Opcode 0x5 (divide) with `b` ≠ 0 gives `res` = floor(`a`/`b`) and `ovf` = floor(`a`·2^16/`b`) mod 2^16. `ovf_we` = 1.
- R6: Opcode 0x5 with `b` = 0 gives `res` = 0 and `ovf` = 0, with `ovf_we` = 1.
- R7: Opcode 0x6 (modulo) gives `res` = `a` mod `b`, or 0 when `b` = 0. `ovf_we` = 0.
- R8: Opcode 0x7 (left shift) forms `a`·2^`b` as a 32-bit value, with `res` taking bits 15:0 and `ovf` taking bits 31:16. `ovf_we` = 1.
- R9: Opcode 0x8 (right shift) gives `res` = `a` >> `b` and `ovf` = ((`a`·2^16) >> `b`) mod 2^16. `ovf_we` = 1.
- R10: For opcodes 0x7 and 0x8, a shift amount `b` ≥ 32 gives `res` = 0 and `ovf` = 0.
- R11: Opcodes 0x9, 0xa and 0xb give `a` AND `b`, `a` OR `b` and `a` XOR `b` respectively, each with `ovf_we` = 0.
- R12: Opcodes 0x0 and 0xc–0xf give `res` = `a`, `ovf` = 0 and `ovf_we` = 0.
- R13: Whenever `ovf_we` = 0, `ovf` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| a | input | 16 | First operand (destination value) |
| b | input | 16 | Second operand |
| res | output | 16 | Value to write to the destination |
| ovf | output | 16 | New overflow word |
| ovf_we | output | 1 | Overflow word write enable |

## Verification
Every result of this unit is due in the same cycle its inputs are applied, because no register lies between any input and any output. The bench drives the opcode and the operands on the falling clock edge. It waits one nanosecond for the logic to settle and then compares all three outputs against a model computed from the requirements. Each sample is therefore taken well clear of the rising edge and before the next stimulus. The directed scenarios cover carry, borrow, division by zero, shift amounts of 15, 16, 31 and 32 and above, and unused opcodes. A final scenario sweeps random operands over all sixteen opcodes.

// File: rtl/ovw_alu.sv
module ovw_alu #(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic [W-1:0] ovf,
  output logic         ovf_we
);
  localparam int W2 = 2 * W;

  logic [W:0]    sum;
  logic [W:0]    dif;
  logic [W2-1:0] prod;
  logic [W2-1:0] shl;
  logic [W2-1:0] shr;
  logic          bzero;

  assign sum   = {1'b0, a} + {1'b0, b};
  assign dif   = {1'b0, a} - {1'b0, b};
  assign prod  = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign shl   = {{W{1'b0}}, a} << b;
  assign shr   = {a, {W{1'b0}}} >> b;
  assign bzero = (b == '0);

  always_comb begin
    res    = a;
    ovf    = '0;
    ovf_we = 1'b0;
    case (op)
      4'h1: res = b;
      4'h2: begin
        res    = sum[W-1:0];
        ovf    = {{(W-1){1'b0}}, sum[W]};
        ovf_we = 1'b1;
      end
      4'h3: begin
        res    = dif[W-1:0];
        ovf    = {W{dif[W]}};
        ovf_we = 1'b1;
      end
      4'h4: begin
        res    = prod[W-1:0];
        ovf    = prod[W2-1:W];
        ovf_we = 1'b1;
      end
      4'h5: begin
        ovf_we = 1'b1;
        if (bzero) begin
          res = '0;
          ovf = '0;
        end else begin
          res = a / b;
          ovf = W'(({a, {W{1'b0}}}) / {{W{1'b0}}, b});
        end
      end
      4'h6: res = bzero ? '0 : a % b;
      4'h7: begin
        res    = shl[W-1:0];
        ovf    = shl[W2-1:W];
        ovf_we = 1'b1;
      end
      4'h8: begin
        res    = shr[W2-1:W];
        ovf    = shr[W-1:0];
        ovf_we = 1'b1;
      end
      4'h9: res = a & b;
      4'ha: res = a | b;
      4'hb: res = a ^ b;
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({op, a, b})) begin
      assert_quiet_ovf_R13: assert (ovf_we || ovf == '0)
        else $error("ovf nonzero without write enable");
      assert_add_ovf_R2: assert (op != 4'h2 || ovf == 1 || ovf == 0)
        else $error("add overflow word not 0 or 1");
      assert_add_carry_R2: assert (op != 4'h2 || (ovf[0] == (res < a)))
        else $error("add carry inconsistent with wrap");
      assert_sub_mask_R3: assert (op != 4'h3 || ovf == '0 || ovf == '1)
        else $error("sub overflow word not a full mask");
      assert_divzero_R6: assert (!(op == 4'h5 && b == '0) || (res == '0 && ovf == '0 && ovf_we))
        else $error("divide by zero not cleared");
      assert_modzero_R7: assert (!(op == 4'h6 && b == '0) || res == '0)
        else $error("modulo by zero not cleared");
      assert_bigshift_R10: assert (!((op == 4'h7 || op == 4'h8) && b >= 16'd32) || (res == '0 && ovf == '0))
        else $error("large shift not cleared");
      assert_no_we_R11: assert (!(op == 4'h1 || op == 4'h6 || op == 4'h9 || op == 4'ha || op == 4'hb) || !ovf_we)
        else $error("overflow written by non-arithmetic op");
    end
  end
endmodule

// File: tb/test_ovw_alu.sv
module test_ovw_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  op = '0;
  logic [15:0] a = '0, b = '0;
  logic [15:0] res, ovf;
  logic        ovf_we;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ovw_alu i_ovw_alu (.op(op), .a(a), .b(b), .res(res), .ovf(ovf), .ovf_we(ovf_we));

  function automatic void model(input logic [3:0] o, input longint unsigned x, input longint unsigned y,
                                output logic [15:0] r, output logic [15:0] v, output logic we);
    longint unsigned t;
    r = x[15:0]; v = 0; we = 0;
    case (o)
      4'h1: r = y[15:0];
      4'h2: begin t = x + y; r = t[15:0]; v = (t > 65535) ? 16'h0001 : 16'h0000; we = 1; end
      4'h3: begin t = x + 65536 - y; r = t[15:0]; v = (y > x) ? 16'hffff : 16'h0000; we = 1; end
      4'h4: begin t = x * y; r = t[15:0]; v = t[31:16]; we = 1; end
      4'h5: begin
        we = 1;
        if (y == 0) begin r = 0; v = 0; end
        else begin t = x / y; r = t[15:0]; t = (x * 65536) / y; v = t[15:0]; end
      end
      4'h6: begin t = (y == 0) ? 0 : x % y; r = t[15:0]; end
      4'h7: begin
        we = 1;
        if (y >= 32) begin r = 0; v = 0; end
        else begin t = x << y; r = t[15:0]; v = t[31:16]; end
      end
      4'h8: begin
        we = 1;
        if (y >= 32) begin r = 0; v = 0; end
        else begin t = x >> y; r = t[15:0]; t = (x << 16) >> y; v = t[15:0]; end
      end
      4'h9: begin t = x & y; r = t[15:0]; end
      4'ha: begin t = x | y; r = t[15:0]; end
      4'hb: begin t = x ^ y; r = t[15:0]; end
      default: ;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%h a=%h b=%h: got %h expected %h", req, what, op, a, b, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [3:0] o, input logic [15:0] x, input logic [15:0] y);
    logic [15:0] er, ev; logic ew;
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
    model(o, x, y, er, ev, ew);
    check(req, "res", res, er);
    check(req, "ovf", ovf, ev);
    check(req, "ovf_we", {15'b0, ovf_we}, {15'b0, ew});
    if (!ovf_we) check("R13", "quiet ovf", ovf, 16'h0000);
  endtask

  task automatic t_idle();     apply("R12", 4'h0, 16'h0000, 16'h0000); endtask
  task automatic t_set();      apply("R1", 4'h1, 16'h1234, 16'habcd); apply("R1", 4'h1, 16'hffff, 16'h0000); endtask
  task automatic t_add();
    apply("R2", 4'h2, 16'h0001, 16'h0002); apply("R2", 4'h2, 16'hffff, 16'h0001);
    apply("R2", 4'h2, 16'h8000, 16'h8000); apply("R2", 4'h2, 16'hfffe, 16'h0001);
  endtask
  task automatic t_sub();
    apply("R3", 4'h3, 16'h0005, 16'h0003); apply("R3", 4'h3, 16'h0003, 16'h0005);
    apply("R3", 4'h3, 16'h7777, 16'h7777); apply("R3", 4'h3, 16'h0000, 16'hffff);
  endtask
  task automatic t_mul();
    apply("R4", 4'h4, 16'hffff, 16'hffff); apply("R4", 4'h4, 16'h0100, 16'h0100); apply("R4", 4'h4, 16'h0003, 16'h0007);
  endtask
  task automatic t_div();
    apply("R5", 4'h5, 16'h0007, 16'h0002); apply("R5", 4'h5, 16'h0001, 16'h0003);
    apply("R5", 4'h5, 16'hffff, 16'h0001); apply("R5", 4'h5, 16'h0005, 16'h0007);
  endtask
  task automatic t_divzero();  apply("R6", 4'h5, 16'h1234, 16'h0000); apply("R6", 4'h5, 16'h0000, 16'h0000); endtask
  task automatic t_mod();
    apply("R7", 4'h6, 16'h0011, 16'h0005); apply("R7", 4'h6, 16'h1234, 16'h0000); apply("R7", 4'h6, 16'h0003, 16'h0009);
  endtask
  task automatic t_shl();
    apply("R8", 4'h7, 16'h8001, 16'h0001); apply("R8", 4'h7, 16'hffff, 16'h0010);
    apply("R8", 4'h7, 16'h0001, 16'h001f); apply("R8", 4'h7, 16'h1234, 16'h0000);
  endtask
  task automatic t_shr();
    apply("R9", 4'h8, 16'h8001, 16'h0001); apply("R9", 4'h8, 16'hffff, 16'h000f);
    apply("R9", 4'h8, 16'hffff, 16'h0010); apply("R9", 4'h8, 16'h8000, 16'h001f);
  endtask
  task automatic t_bigshift();
    apply("R10", 4'h7, 16'hffff, 16'h0020); apply("R10", 4'h8, 16'hffff, 16'h0020);
    apply("R10", 4'h7, 16'h0001, 16'hffff); apply("R10", 4'h8, 16'h8000, 16'h0100);
  endtask
  task automatic t_logic();
    apply("R11", 4'h9, 16'hf0f0, 16'hff00); apply("R11", 4'ha, 16'hf0f0, 16'h0f0f); apply("R11", 4'hb, 16'haaaa, 16'hffff);
  endtask
  task automatic t_unused();
    for (int k = 12; k < 16; k++) apply("R12", 4'(k), 16'h5a5a, 16'h1111);
    apply("R12", 4'h0, 16'hbeef, 16'hffff);
  endtask
  task automatic t_random();
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] x, y;
      x = 16'($urandom); y = 16'($urandom);
      if (n % 4 == 0) y = y & 16'h003f;
      apply("R13", 4'(n % 16), x, y);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle(); t_set(); t_add(); t_sub(); t_mul(); t_div(); t_divzero();
    t_mod(); t_shl(); t_shr(); t_bigshift(); t_logic(); t_unused(); t_random();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule